// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block collects the per-pin pending flags of a large GPIO array and condenses them into a compact summary, one summary bit for each group of four consecutive pins. With the default 184 pins there are 46 summary bits. Software reads them through two 32-bit status words: the low word carries bits 31:0 and the high word carries bits 45:32. A single interrupt line goes to the processor.

The interrupt line does not follow the summary level. It fires when a summary bit becomes newly set and stays high until software writes the end-of-interrupt bit in the control word. That write drops the line. If any group is still pending, the line rises again one clock edge later, so a source left unserviced is never lost. Per-pin detection and the per-pin register decode live outside this block. Here they are only the `pend_i` vector, where pin n's own register sits at byte offset 4n in its neighbour's map.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit k is the OR of the pending flags of pins 4k, 4k+1, 4k+2 and 4k+3. Any one or more pending pins in a group set that bit.
- R2: A read at byte address 0x0 returns summary bits 31:0 in data bits 31:0. A pin change shows in the read data after one rising clock edge.
- R3: A read at byte address 0x4 returns summary bits 45:32 in data bits 13:0. Data bits 31:14 always read 0.
- R4: When a summary bit goes from clear to set while `irq_o` is low, `irq_o` goes high after the second rising edge following the pin change.
- R5: Once high, `irq_o` stays high until an end-of-interrupt write, even if every pending flag clears.
- R6: A write to byte address 0x8 with data bit 8 set is an end-of-interrupt. `irq_o` is low after that edge. A write there with bit 8 clear has no effect on `irq_o`.
- R7: If any summary bit is set in the cycle after an end-of-interrupt, `irq_o` rises again on the next edge.
- R8: The control word at 0x8 always reads as 0, including the self-clearing end-of-interrupt bit.
- R9: Writes to addresses 0x0 and 0x4 are ignored, so the status reads are unchanged by them.
- R10: After reset, `irq_o` is low and both status words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 184 | Pending flag per pin, already detected per pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the re-arm after an end-of-interrupt. The pins have to stay pending across the write, so that the line first drops and then comes back exactly one edge later. The bench holds a pin pending, raises the line, and issues the end-of-interrupt at a negative edge. It then samples `irq_o` low at the next negative edge and high one cycle after that. It also repeats the write with no pin pending, to show that the line then stays low.

// File: rtl/gpio_irq_summary_pkg.sv
package gpio_irq_summary_pkg;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 4;
    localparam int GROUP_PINS  = 4;
    localparam logic [ADDR_W-1:0] ADDR_SUM_LO = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_SUM_HI = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h8;
    localparam int EOI_POS     = 8;
endpackage

// File: rtl/gpio_pin_grouper.sv
module gpio_pin_grouper #(
    parameter int NPINS = 184,
    parameter int GRP   = 4,
    localparam int NSUM = (NPINS + GRP - 1) / GRP
) (
    input  logic [NPINS-1:0] pend_i,
    output logic [NSUM-1:0]  sum_o
);
    for (genvar k = 0; k < NSUM; k++) begin : g_grp
        always_comb begin
            sum_o[k] = 1'b0;
            for (int j = 0; j < GRP; j++) begin
                if (k * GRP + j < NPINS) sum_o[k] = sum_o[k] | pend_i[k * GRP + j];
            end
        end
    end
endmodule

// File: rtl/gpio_sum_readmux.sv
module gpio_sum_readmux
    import gpio_irq_summary_pkg::*;
#(
    parameter int NSUM = 46
) (
    input  logic [NSUM-1:0]   sum_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [REG_W-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_SUM_LO) begin
            for (int i = 0; i < REG_W; i++) begin
                if (i < NSUM) rdata_o[i] = sum_i[i];
            end
        end else if (addr_i == ADDR_SUM_HI) begin
            for (int i = 0; i < REG_W; i++) begin
                if (i + REG_W < NSUM) rdata_o[i] = sum_i[i + REG_W];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
    import gpio_irq_summary_pkg::*;
#(
    parameter int NPINS = 184
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pend_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam int NSUM = (NPINS + GROUP_PINS - 1) / GROUP_PINS;

    typedef struct packed {
        logic [NSUM-1:0] sum;
        logic [NSUM-1:0] seen;
        logic            irq;
    } st_t;

    st_t             st_d, st_q;
    logic [NSUM-1:0] grp_sum;
    logic [NSUM-1:0] fresh;
    logic            eoi;
    logic            unused_wdata;

    gpio_pin_grouper #(.NPINS(NPINS), .GRP(GROUP_PINS)) u_grp (
        .pend_i (pend_i),
        .sum_o  (grp_sum)
    );

    gpio_sum_readmux #(.NSUM(NSUM)) u_rd (
        .sum_i   (st_q.sum),
        .addr_i  (addr_i),
        .rdata_o (rdata_o)
    );

    assign eoi          = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[EOI_POS];
    assign unused_wdata = ^{wdata_i[REG_W-1:EOI_POS+1], wdata_i[EOI_POS-1:0]};

    always_comb begin
        st_d     = st_q;
        st_d.sum = grp_sum;
        fresh    = st_q.sum & ~st_q.seen;
        if (eoi) begin
            st_d.irq  = 1'b0;
            st_d.seen = '0;
        end else begin
            st_d.irq  = st_q.irq | (|fresh);
            st_d.seen = st_q.sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk
    import gpio_irq_summary_pkg::*;
#(
    parameter int NSUM = 46
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eoi,
    input logic [NSUM-1:0]   sum,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic              irq_o
);
    // R5: the line holds until an end-of-interrupt
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !eoi) |=> irq_o);
    // R6: end-of-interrupt drops the line
    a_r6_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq_o);
    // R7: re-arm when groups remain pending
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        eoi ##1 ((|sum) && !eoi) |=> irq_o);
    // R5/R6: the line only falls after an end-of-interrupt
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(eoi));

    always_comb begin
        if (rst_n && addr_i == ADDR_SUM_HI)
            a_r3_hi_upper_zero: assert ((rdata_o >> (NSUM - REG_W)) == '0);
        if (rst_n && addr_i == ADDR_CTRL)
            a_r8_ctrl_reads_zero: assert (rdata_o == '0);
    end
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(.NSUM(NSUM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoi     (eoi),
    .sum     (st_q.sum),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
);

// File: tb/gpio_irq_summary_test.sv
module gpio_irq_summary_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 184;

    typedef struct packed {
        logic [7:0]  pin;
        logic [31:0] lo;
        logic [31:0] hi;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{8'd0,   32'h0000_0001, 32'h0},
        '{8'd3,   32'h0000_0001, 32'h0},
        '{8'd4,   32'h0000_0002, 32'h0},
        '{8'd42,  32'h0000_0400, 32'h0},
        '{8'd127, 32'h8000_0000, 32'h0},
        '{8'd128, 32'h0,         32'h0000_0001},
        '{8'd170, 32'h0,         32'h0000_0400},
        '{8'd183, 32'h0,         32'h0000_2000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pend = '0;
    logic              wr_en = 1'b0;
    logic [3:0]        addr = 4'h0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_irq_summary #(.NPINS(NPINS)) uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic eoi_write();
        wr(4'h8, 32'h0000_0100);
    endtask

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 irq", {31'd0, irq}, 32'd0);
        rd(4'h0, v); check("R10 lo", v, 32'd0);
        rd(4'h4, v); check("R10 hi", v, 32'd0);

        // table walk: R1 R2 R3 single pin mapping
        foreach (TABLE[i]) begin
            @(negedge clk);
            pend = '0;
            pend[TABLE[i].pin] = 1'b1;
            @(negedge clk);
            rd(4'h0, v); check("R2 lo map", v, TABLE[i].lo);
            rd(4'h4, v); check("R3 hi map", v, TABLE[i].hi);
        end
        pend = '0;
        @(negedge clk);
        eoi_write();
        @(negedge clk);
        check("R6 cleared after table", {31'd0, irq}, 32'd0);

        // R1 several pins in one group, one bit only
        pend[9] = 1'b1; pend[10] = 1'b1; pend[11] = 1'b1;
        @(negedge clk);
        rd(4'h0, v); check("R1 group or", v, 32'h0000_0004);
        pend = '0;
        @(negedge clk);
        eoi_write();
        @(negedge clk);

        // R3 all pins: upper high bits zero
        pend = '1;
        @(negedge clk);
        rd(4'h0, v); check("R1 all lo", v, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R3 all hi", v, 32'h0000_3FFF);
        // R9 writes ignored
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
        rd(4'h0, v); check("R9 lo unchanged", v, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R9 hi unchanged", v, 32'h0000_3FFF);
        // R8 control reads zero
        rd(4'h8, v); check("R8 ctrl zero", v, 32'd0);
        pend = '0;
        @(negedge clk); @(negedge clk);
        eoi_write();
        @(negedge clk);
        check("R6 quiet", {31'd0, irq}, 32'd0);

        // R4 latency
        pend[50] = 1'b1;
        @(negedge clk);
        check("R4 not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R4 raised", {31'd0, irq}, 32'd1);
        // R5 holds after pin clears
        pend = '0;
        repeat (4) @(negedge clk);
        check("R5 hold", {31'd0, irq}, 32'd1);
        // R6 write without EOI bit has no effect
        wr(4'h8, 32'hFFFF_FEFF);
        check("R6 no-eoi write", {31'd0, irq}, 32'd1);
        // R6 EOI with nothing pending
        eoi_write();
        check("R6 eoi drop", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R7 no rearm when idle", {31'd0, irq}, 32'd0);

        // R7 re-arm with pin still pending
        pend[100] = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 raised again", {31'd0, irq}, 32'd1);
        eoi_write();
        check("R6 drop while pending", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R7 rearm", {31'd0, irq}, 32'd1);
        rd(4'h8, v); check("R8 eoi self-clear", v, 32'd0);
        pend = '0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule